// File: doc/BRIEF.md
# I2C receive acknowledge and clock-stretch controller

This block sits on the receive side of an I2C byte engine. It watches the filtered SCL and SDA levels and counts the clock pulses of each byte. Data bits are shifted in MSB first. A data-ready flag is raised at a clock edge that software selects. In receive mode the block drives the ninth (acknowledge) bit from a value that software controls. It can also stretch SCL by pulling it low until software acts. The block drives neither line high: for each line it gives only an enable that pulls the line low.

Software reaches the block through a one-cycle write strobe carrying a four-bit control word and a one-cycle read strobe for the receive data register. The acknowledge value has a write guard: it changes only when a separate enable bit was already set before the write. There are two kinds of clock hold. An early hold starts after the eighth clock and ends when software writes an acknowledge value. A wait hold starts after the ninth clock and ends when software reads the data.

Top module: `i2c_rx_ack_stretch`

## Requirements
- R1: After reset, ctlRdData reads 0, rxReady is 0 and neither line is pulled low.
- R2: Control write bits are: 0 = acknowledge value, 1 = acknowledge write enable, 2 = flag-at-eighth select, 3 = wait enable. ctlRdData returns the same bits in the same positions, plus bit 4 = received acknowledge, and bits 7:5 read 0. The acknowledge value takes the written bit only if the enable bit was 1 before that write. A single write of 1 to both bits leaves the value at 0.
- R3: In receive mode, during the ninth clock, sdaPullLow is 1 when the acknowledge value is 0 (ACK) and 0 when it is 1 (NACK). Outside the acknowledge slot SDA is never pulled.
- R4: In transmit mode, the SDA level at the ninth SCL rising edge is stored in status bit 4 (0 = ACK seen, 1 = NACK seen).
- R5: Received bits are taken MSB first, and rxData holds the byte once its eighth bit is sampled. A pulse on dataRd clears rxReady.
- R6: With flag-at-eighth select 0, rxReady rises on the ninth SCL rising edge, and SCL is not held after the eighth clock.
- R7: With flag-at-eighth select 1, rxReady rises on the eighth SCL rising edge. SCL is held low from the eighth falling edge until a control write that the enable bit accepts for the acknowledge value.
- R8: With wait enabled, SCL is held low from the ninth falling edge until a dataRd pulse.
- R9: In transmit mode the wait enable and the flag select have no effect: SCL is never held and rxReady never rises.
- R10: A START or repeated START condition (SDA falling while SCL is high) resets the bit count, so a byte that follows a broken-off byte is received intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Filtered SCL line level |
| sdaIn | input | 1 | Filtered SDA line level |
| rxMode | input | 1 | 1 = receive mode, 0 = transmit mode |
| ctlWr | input | 1 | Control write strobe |
| ctlWrData | input | 4 | Control write value |
| dataRd | input | 1 | Receive data register read strobe |
| ctlRdData | output | 8 | Control and status read value |
| rxData | output | DATA_W | Last received byte |
| rxReady | output | 1 | Receive data ready flag |
| sclPullLow | output | 1 | Pull-low enable for SCL |
| sdaPullLow | output | 1 | Pull-low enable for SDA |

## Verification
The hardest case to reach is a hold that has to be released by software in the middle of a byte. The bus master in the bench then stalls on a low SCL line and can only go on after a software action. The bench models the lines as open-drain, and a separate software process reacts to the data-ready flag. That process waits until it sees the hold and checks that SCL stays low. It then makes the release write or read and confirms that the line comes free, while the master task continues blocked on the real line level. A repeated START injected after three bits covers the counter reset.

// File: rtl/i2c_rx_ack_pkg.sv
package i2c_rx_ack_pkg;

  localparam int CTL_WR_W = 4;
  localparam int CTL_RD_W = 8;

  localparam int FLD_ACK_VAL = 0;
  localparam int FLD_ACK_EN  = 1;
  localparam int FLD_EARLY   = 2;
  localparam int FLD_WAIT    = 3;
  localparam int FLD_ACK_RX  = 4;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic lastDataRise;
    logic ackRise;
    logic lastDataFall;
    logic ackFall;
    logic startSeen;
    logic stopSeen;
  } lineEvt_t;

endpackage

// File: rtl/i2c_rx_ack_dp.sv
module i2c_rx_ack_dp
  import i2c_rx_ack_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              rxMode,
  output lineEvt_t          evt,
  output logic [DATA_W-1:0] rxData,
  output logic              ackRcvd
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] AFTER_ACK = CNT_W'(DATA_W + 1);

  logic             sclPrev;
  logic             sdaPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [DATA_W-2:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
    end
  end

  always_comb begin
    evt.sclRise      = sclIn & ~sclPrev;
    evt.sclFall      = ~sclIn & sclPrev;
    evt.startSeen    = sclIn & sclPrev & sdaPrev & ~sdaIn;
    evt.stopSeen     = sclIn & sclPrev & ~sdaPrev & sdaIn;
    evt.lastDataRise = evt.sclRise & (bitCnt == LAST_DATA);
    evt.ackRise      = evt.sclRise & (bitCnt == ACK_POS);
    evt.lastDataFall = evt.sclFall & (bitCnt == ACK_POS);
    evt.ackFall      = evt.sclFall & (bitCnt == AFTER_ACK);
  end

  // bit counter: counts rising edges of the current byte, R10
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (evt.startSeen || evt.stopSeen || evt.ackFall) begin
      bitCnt <= '0;
    end else if (evt.sclRise && (bitCnt != AFTER_ACK)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      ackRcvd  <= 1'b0;
    end else begin
      if (evt.sclRise && (bitCnt < ACK_POS)) begin
        shiftReg <= {shiftReg[DATA_W-3:0], sdaIn};
      end
      if (evt.lastDataRise && rxMode) begin
        rxData <= {shiftReg, sdaIn};
      end
      if (evt.ackRise && !rxMode) begin
        ackRcvd <= sdaIn;
      end
    end
  end

endmodule

// File: rtl/i2c_rx_ack_ctl.sv
module i2c_rx_ack_ctl
  import i2c_rx_ack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  lineEvt_t            evt,
  input  logic                rxMode,
  input  logic                ctlWr,
  input  logic [CTL_WR_W-1:0] ctlWrData,
  input  logic                dataRd,
  output logic                ackVal,
  output logic                ackWrEn,
  output logic                earlyFlag,
  output logic                waitEn,
  output logic                rxReady,
  output logic                sclPullLow,
  output logic                sdaPullLow
);

  logic ackAccept;
  logic ackSlot;
  logic holdEarly;
  logic holdWait;
  logic flagSet;

  assign ackAccept = ctlWr & ackWrEn;
  assign flagSet   = rxMode & (earlyFlag ? evt.lastDataRise : evt.ackRise);

  // control register with guarded acknowledge value, R2
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackVal    <= 1'b0;
      ackWrEn   <= 1'b0;
      earlyFlag <= 1'b0;
      waitEn    <= 1'b0;
    end else if (ctlWr) begin
      ackWrEn   <= ctlWrData[FLD_ACK_EN];
      earlyFlag <= ctlWrData[FLD_EARLY];
      waitEn    <= ctlWrData[FLD_WAIT];
      if (ackWrEn) begin
        ackVal <= ctlWrData[FLD_ACK_VAL];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReady <= 1'b0;
    end else if (flagSet) begin
      rxReady <= 1'b1;
    end else if (dataRd) begin
      rxReady <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackSlot <= 1'b0;
    end else if (evt.startSeen || evt.stopSeen || evt.ackFall) begin
      ackSlot <= 1'b0;
    end else if (evt.lastDataFall && rxMode) begin
      ackSlot <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdEarly <= 1'b0;
      holdWait  <= 1'b0;
    end else begin
      if (evt.lastDataFall && rxMode && earlyFlag) begin
        holdEarly <= 1'b1;
      end else if (ackAccept || evt.stopSeen) begin
        holdEarly <= 1'b0;
      end
      if (evt.ackFall && rxMode && waitEn) begin
        holdWait <= 1'b1;
      end else if (dataRd || evt.stopSeen) begin
        holdWait <= 1'b0;
      end
    end
  end

  assign sclPullLow = holdEarly | holdWait;
  assign sdaPullLow = ackSlot & ~ackVal;

endmodule

// File: rtl/i2c_rx_ack_stretch.sv
module i2c_rx_ack_stretch
  import i2c_rx_ack_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic                rxMode,
  input  logic                ctlWr,
  input  logic [CTL_WR_W-1:0] ctlWrData,
  input  logic                dataRd,
  output logic [CTL_RD_W-1:0] ctlRdData,
  output logic [DATA_W-1:0]   rxData,
  output logic                rxReady,
  output logic                sclPullLow,
  output logic                sdaPullLow
);

  lineEvt_t evt;
  logic     ackRcvd;
  logic     ackVal;
  logic     ackWrEn;
  logic     earlyFlag;
  logic     waitEn;

  i2c_rx_ack_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .rxMode  (rxMode),
    .evt     (evt),
    .rxData  (rxData),
    .ackRcvd (ackRcvd)
  );

  i2c_rx_ack_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .rxMode     (rxMode),
    .ctlWr      (ctlWr),
    .ctlWrData  (ctlWrData),
    .dataRd     (dataRd),
    .ackVal     (ackVal),
    .ackWrEn    (ackWrEn),
    .earlyFlag  (earlyFlag),
    .waitEn     (waitEn),
    .rxReady    (rxReady),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow)
  );

  always_comb begin
    ctlRdData              = '0;
    ctlRdData[FLD_ACK_VAL] = ackVal;
    ctlRdData[FLD_ACK_EN]  = ackWrEn;
    ctlRdData[FLD_EARLY]   = earlyFlag;
    ctlRdData[FLD_WAIT]    = waitEn;
    ctlRdData[FLD_ACK_RX]  = ackRcvd;
  end

endmodule

// File: rtl/i2c_rx_ack_stretch_chk.sv
module i2c_rx_ack_stretch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       rxMode,
  input logic       ctlWr,
  input logic       dataRd,
  input logic [7:0] ctlRdData,
  input logic       rxReady,
  input logic       sclPullLow,
  input logic       sdaPullLow
);

  // R9: a clock hold can only start from receive mode
  assert_rx_only_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclPullLow) |-> $past(rxMode));

  // R7, R8: a hold ends only after a control write, a data read or a high SCL
  assert_release_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclPullLow) |-> ($past(ctlWr) || $past(dataRd) || $past(sclIn)));

  // R5: the ready flag drops only after a data read
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(dataRd));

  // R2: a write without prior enable keeps the acknowledge value
  assert_ack_protect_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !ctlRdData[1]) |=> $stable(ctlRdData[0]));

  // R3: SDA starts being pulled only while SCL is low
  assert_sda_change_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !$past(sclIn));

endmodule

bind i2c_rx_ack_stretch i2c_rx_ack_stretch_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .rxMode     (rxMode),
  .ctlWr      (ctlWr),
  .dataRd     (dataRd),
  .ctlRdData  (ctlRdData),
  .rxReady    (rxReady),
  .sclPullLow (sclPullLow),
  .sdaPullLow (sdaPullLow)
);

// File: tb/i2c_rx_ack_stretch_bench.sv
module i2c_rx_ack_stretch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic rxMode = 1'b1;
  logic ctlWr = 1'b0;
  logic [3:0] ctlWrData = '0;
  logic dataRd = 1'b0;
  logic [7:0] ctlRdData;
  logic [DATA_W-1:0] rxData;
  logic rxReady;
  logic sclPullLow;
  logic sdaPullLow;
  logic sclIn;
  logic sdaIn;

  int checks = 0;
  int errors = 0;
  int masterBit = 0;
  int pullCnt = 0;
  bit swEarly = 0;
  bit swWait = 0;
  logic [DATA_W-1:0] expQ[$];
  logic ackPlan[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sclIn = sclM & ~sclPullLow;
  assign sdaIn = sdaM & ~sdaPullLow;

  i2c_rx_ack_stretch #(.DATA_W(DATA_W)) u_i2c_rx_ack_stretch (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .rxMode     (rxMode),
    .ctlWr      (ctlWr),
    .ctlWrData  (ctlWrData),
    .dataRd     (dataRd),
    .ctlRdData  (ctlRdData),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (sclPullLow) pullCnt++;

  task automatic ctlWrite(input logic [3:0] d);
    @(negedge clk);
    ctlWr = 1'b1;
    ctlWrData = d;
    @(negedge clk);
    ctlWr = 1'b0;
  endtask

  task automatic dataRead();
    @(negedge clk);
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
  endtask

  task automatic waitSclHigh();
    while (sclIn !== 1'b1) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic seen);
    @(negedge clk);
    sdaM = b;
    repeat (HALF) @(negedge clk);
    sclM = 1'b1;
    waitSclHigh();
    masterBit++;
    repeat (HALF) @(negedge clk);
    seen = sdaIn;
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [DATA_W-1:0] v, input logic ackLine, output logic ackSeen);
    logic dummy;
    masterBit = 0;
    if (rxMode) expQ.push_back(v);
    for (int i = DATA_W - 1; i >= 0; i--) sendBit(v[i], dummy);
    sendBit(ackLine, ackSeen);
  endtask

  task automatic startCond();
    @(negedge clk);
    sdaM = 1'b1;
    repeat (HALF) @(negedge clk);
    sclM = 1'b1;
    waitSclHigh();
    repeat (HALF) @(negedge clk);
    sdaM = 1'b0;
    repeat (HALF) @(negedge clk);
    sclM = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic stopCond();
    @(negedge clk);
    sdaM = 1'b0;
    repeat (HALF) @(negedge clk);
    sclM = 1'b1;
    waitSclHigh();
    repeat (HALF) @(negedge clk);
    sdaM = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  // monitor and software model: pops the scoreboard and performs releases
  initial begin
    forever begin
      @(posedge rxReady);
      @(negedge clk);
      if (expQ.size() == 0) begin
        chk("R5", "unexpected byte", 1, 0);
      end else begin
        chk("R5", "received byte", int'(rxData), int'(expQ.pop_front()));
      end
      if (swEarly) chk("R7", "flag clock", masterBit, 8);
      else chk("R6", "flag clock", masterBit, 9);
      if (swEarly) begin
        logic a;
        while (!sclPullLow) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R7", "scl held low", int'(sclIn), 0);
        a = ackPlan.pop_front();
        ctlWrite({swWait, 1'b1, 1'b1, a});
        chk("R7", "hold released by ack write", int'(sclPullLow), 0);
      end
      if (swWait) begin
        while (!sclPullLow) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R8", "scl held in wait", int'(sclIn), 0);
        dataRead();
        chk("R8", "hold released by read", int'(sclPullLow), 0);
      end else begin
        dataRead();
      end
      chk("R5", "flag cleared by read", int'(rxReady), 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ackSeen;
    logic dummy;
    repeat (4) @(negedge clk);
    chk("R1", "ctl after reset", int'(ctlRdData), 0);
    chk("R1", "flag after reset", int'(rxReady), 0);
    chk("R1", "scl pull after reset", int'(sclPullLow), 0);
    chk("R1", "sda pull after reset", int'(sdaPullLow), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 write guard
    ctlWrite(4'b0011);
    chk("R2", "both set in one write", int'(ctlRdData[1:0]), 2);
    ctlWrite(4'b0011);
    chk("R2", "ack set with enable", int'(ctlRdData[1:0]), 3);
    ctlWrite(4'b0000);
    chk("R2", "ack cleared with enable", int'(ctlRdData[1:0]), 0);
    ctlWrite(4'b0001);
    chk("R2", "ack blocked", int'(ctlRdData[1:0]), 0);
    ctlWrite(4'b1110);
    chk("R2", "field readback", int'(ctlRdData), 8'h0E);

    // R3, R6: flag at ninth clock, no hold
    ctlWrite(4'b0010);
    ctlWrite(4'b0010);
    swEarly = 0; swWait = 0; rxMode = 1'b1;
    pullCnt = 0;
    startCond();
    sendByte(8'hC3, 1'b1, ackSeen);
    chk("R3", "ack driven low", int'(ackSeen), 0);
    sendByte(8'h81, 1'b1, ackSeen);
    chk("R3", "ack driven low", int'(ackSeen), 0);
    ctlWrite(4'b0011);
    sendByte(8'h7E, 1'b1, ackSeen);
    chk("R3", "nack releases sda", int'(ackSeen), 1);
    stopCond();
    repeat (10) @(negedge clk);
    chk("R6", "no hold cycles", pullCnt, 0);
    chk("R3", "sda idle outside slot", int'(sdaPullLow), 0);

    // R7: flag at eighth clock with hold until ack write
    ctlWrite(4'b0110);
    swEarly = 1; swWait = 0;
    ackPlan.push_back(1'b0);
    ackPlan.push_back(1'b1);
    startCond();
    sendByte(8'h96, 1'b1, ackSeen);
    chk("R7", "ack value after write", int'(ackSeen), 0);
    sendByte(8'h2D, 1'b1, ackSeen);
    chk("R7", "nack value after write", int'(ackSeen), 1);
    stopCond();
    repeat (10) @(negedge clk);

    // R8: wait hold after ninth clock
    ctlWrite(4'b1010);
    ctlWrite(4'b1010);
    swEarly = 0; swWait = 1;
    startCond();
    sendByte(8'h44, 1'b1, ackSeen);
    chk("R3", "ack in wait mode", int'(ackSeen), 0);
    sendByte(8'hBB, 1'b1, ackSeen);
    stopCond();
    repeat (10) @(negedge clk);

    // R4, R9: transmit mode
    ctlWrite(4'b1110);
    swEarly = 1; swWait = 1;
    rxMode = 1'b0;
    pullCnt = 0;
    startCond();
    sendByte(8'hA5, 1'b0, ackSeen);
    chk("R4", "ack captured", int'(ctlRdData[4]), 0);
    sendByte(8'h3C, 1'b1, ackSeen);
    chk("R4", "nack captured", int'(ctlRdData[4]), 1);
    chk("R9", "sda not pulled in transmit", int'(ackSeen), 1);
    stopCond();
    repeat (10) @(negedge clk);
    chk("R9", "no hold in transmit", pullCnt, 0);
    chk("R9", "no flag in transmit", int'(rxReady), 0);

    // R10: repeated START after a broken-off byte
    rxMode = 1'b1;
    ctlWrite(4'b0010);
    swEarly = 0; swWait = 0;
    startCond();
    for (int i = 0; i < 3; i++) sendBit(1'b1, dummy);
    startCond();
    sendByte(8'h5A, 1'b1, ackSeen);
    stopCond();
    repeat (10) @(negedge clk);
    chk("R10", "byte after repeated start", int'(rxData), 8'h5A);
    chk("R5", "scoreboard drained", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule